// File: doc/BRIEF.md
# Double-Banked Routing Tile Configuration Store

This block is the configuration front end of one routing tile. A host broadcasts 32-bit configuration writes to many tiles. Each tile compares the low bits of the address with its own tile identifier. When they match, it decodes a feature number and a register number and stores the low bits of the write data in one select register. Feature 0 stands for the switch box and feature 1 for the connection box. The stored values drive the select lines of the routing multiplexers. In this block those multiplexers appear only as the consumers of `route_sel`.

Every select register exists in two banks, a primary bank and a secondary bank. The `cfg_db` input chooses which bank a write lands in, and it also chooses which bank is read back. The `use_db` input chooses which bank drives the routing selects. This input acts combinationally, with no clock edge. A live route can therefore keep running from the primary bank while a replacement route is loaded into the secondary bank. Raising `use_db` then switches every select in the tile at the same instant.

Top module: `tile_cfg_dbuf`

## Requirements
- R1: The address fields are: tile identifier in bits [15:0], feature number in bits [23:16], register number in bits [31:24]. Valid features are 0 to NUM_FEAT-1 (2 by default) and valid registers are 0 to REGS_PER_FEAT-1 (4 by default). Register (f, r) occupies the field `route_sel[(f*REGS_PER_FEAT+r)*SEL_W +: SEL_W]`, with SEL_W = 4 by default.
- R2: A write whose address bits [15:0] differ from `tile_id` changes no stored value. A read at such an address returns zero.
- R3: A write with `cfg_db` low updates only the primary bank. A write with `cfg_db` high updates only the secondary bank.
- R4: While `use_db` is low, every field of `route_sel` equals the primary bank, whatever the secondary bank holds.
- R5: While `use_db` is high and reset is not active, every field of `route_sel` equals the secondary bank. The change on `route_sel` follows a change of `use_db` with no clock edge.
- R6: On the cycle after a write, a read of the same address with the same `cfg_db` returns the written value. Only the low SEL_W bits of the data are stored, and `cfg_rdata` returns them zero-extended with all upper bits zero.
- R7: `cfg_rdata` is combinational. It shows the bank chosen by `cfg_db` at the current address.
- R8: A feature number of NUM_FEAT or above, or a register number of REGS_PER_FEAT or above, reads as zero, and a write to it changes no stored value.
- R9: Active-low reset clears both banks. While reset is active, `route_sel` is taken from the primary bank even if `use_db` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tile_id | input | 16 | Identifier of this tile |
| cfg_addr | input | 32 | Configuration address: tile identifier, feature number, register number |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_wr | input | 1 | Write strobe |
| cfg_db | input | 1 | Bank used for writes and readback: 0 primary, 1 secondary |
| use_db | input | 1 | Bank that drives the routing selects: 0 primary, 1 secondary |
| cfg_rdata | output | 32 | Readback of the addressed register |
| route_sel | output | 32 | All routing select fields, packed |

## Verification
A table of writes sets different values into both banks, spread across both features and all registers. Each value is read back at once. This shows that the write landed in the chosen bank and in the right field. The bench then switches `use_db` with no clock running and compares every field of `route_sel` against both banks. This separates a correct combinational switch from a partial one or a registered one.

Directed writes cover the remaining cases:
- a foreign tile identifier,
- out-of-range feature and register codes,
- data with upper bits set.

Each of these must leave the stored state unchanged, or drop the extra bits, as seen through readback. A reset while `use_db` is high shows that both banks clear and that the primary bank drives the selects during reset.

// File: rtl/tile_cfg_dbuf.sv
module tile_cfg_dbuf #(
  parameter int ADDR_W        = 32,
  parameter int DATA_W        = 32,
  parameter int TILE_ID_W     = 16,
  parameter int FEAT_W        = 8,
  parameter int REG_W         = 8,
  parameter int REG_LSB       = 24,
  parameter int NUM_FEAT      = 2,
  parameter int REGS_PER_FEAT = 4,
  parameter int SEL_W         = 4
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic [TILE_ID_W-1:0]                       tile_id,
  input  logic [ADDR_W-1:0]                          cfg_addr,
  input  logic [DATA_W-1:0]                          cfg_wdata,
  input  logic                                       cfg_wr,
  input  logic                                       cfg_db,
  input  logic                                       use_db,
  output logic [DATA_W-1:0]                          cfg_rdata,
  output logic [NUM_FEAT*REGS_PER_FEAT*SEL_W-1:0]    route_sel
);

  localparam int NUM_SEL  = NUM_FEAT * REGS_PER_FEAT;
  localparam int FEAT_LSB = TILE_ID_W;

  logic [NUM_SEL-1:0][SEL_W-1:0] pri_q, sec_q;
  logic [NUM_SEL-1:0]            hit;
  logic [SEL_W-1:0]              rd_sel;

  wire              tile_hit = (cfg_addr[TILE_ID_W-1:0] == tile_id);
  wire [FEAT_W-1:0] feat     = cfg_addr[FEAT_LSB +: FEAT_W];
  wire [REG_W-1:0]  regn     = cfg_addr[REG_LSB +: REG_W];
  wire              code_ok  = (feat < FEAT_W'(NUM_FEAT)) && (regn < REG_W'(REGS_PER_FEAT));
  wire              unused_wdata_hi = ^cfg_wdata[DATA_W-1:SEL_W];

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
    assign hit[i] = tile_hit
                 && (feat == FEAT_W'(i / REGS_PER_FEAT))
                 && (regn == REG_W'(i % REGS_PER_FEAT));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pri_q[i] <= '0;
        sec_q[i] <= '0;
      end else if (cfg_wr && hit[i]) begin
        if (cfg_db) sec_q[i] <= cfg_wdata[SEL_W-1:0];
        else        pri_q[i] <= cfg_wdata[SEL_W-1:0];
      end
    end
  end

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NUM_SEL; i++)
      if (hit[i]) rd_sel = cfg_db ? sec_q[i] : pri_q[i];
  end

  assign cfg_rdata = DATA_W'(rd_sel);
  assign route_sel = (use_db && rst_n) ? sec_q : pri_q;

  AST_FOREIGN_TILE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !tile_hit) |=> ($stable(pri_q) && $stable(sec_q)));  // R2

  AST_PRIMARY_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_db) |=> $stable(sec_q));  // R3

  AST_SECONDARY_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_db) |=> $stable(pri_q));  // R3

  AST_READBACK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && tile_hit && code_ok) |=>
      ((cfg_addr != $past(cfg_addr)) || (cfg_db != $past(cfg_db)) || (tile_id != $past(tile_id)) ||
       (cfg_rdata == DATA_W'($past(cfg_wdata[SEL_W-1:0])))));  // R6

  AST_BAD_CODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !code_ok) |=> ($stable(pri_q) && $stable(sec_q)));  // R8

  always_comb begin
    if (rst_n && !code_ok)
      AST_BAD_CODE_READS_ZERO: assert (cfg_rdata == '0);  // R8
  end

endmodule

// File: tb/tile_cfg_dbuf_tb_top.sv
`timescale 1ns/1ps
module tile_cfg_dbuf_tb_top;

  localparam int NF = 2, NR = 4, SW = 4, NS = NF * NR;
  localparam logic [15:0] MY_ID = 16'hA5C3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tile_id = MY_ID;
  logic [31:0] cfg_addr = '0, cfg_wdata = '0;
  logic        cfg_wr = 1'b0, cfg_db = 1'b0, use_db = 1'b0;
  logic [31:0] cfg_rdata;
  logic [NS*SW-1:0] route_sel;

  int n_chk = 0, n_bad = 0;
  logic [SW-1:0] m_pri [NS];
  logic [SW-1:0] m_sec [NS];

  always #2.5 clk = ~clk;

  tile_cfg_dbuf dut_i (
    .clk(clk), .rst_n(rst_n), .tile_id(tile_id), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_wr(cfg_wr), .cfg_db(cfg_db), .use_db(use_db),
    .cfg_rdata(cfg_rdata), .route_sel(route_sel)
  );

  // {feature, register, bank, data}
  localparam logic [48:0] VEC [10] = '{
    {8'd0, 8'd0, 1'b0, 32'h0000_0003},
    {8'd0, 8'd1, 1'b0, 32'h0000_000A},
    {8'd0, 8'd3, 1'b0, 32'h0000_0005},
    {8'd1, 8'd0, 1'b0, 32'h0000_000F},
    {8'd1, 8'd2, 1'b0, 32'h0000_0001},
    {8'd0, 8'd0, 1'b1, 32'h0000_000C},
    {8'd0, 8'd2, 1'b1, 32'h0000_0007},
    {8'd1, 8'd1, 1'b1, 32'h0000_0009},
    {8'd1, 8'd3, 1'b1, 32'h0000_0006},
    {8'd1, 8'd2, 1'b1, 32'h0000_000E}
  };

  function automatic logic [31:0] mk_addr(input logic [7:0] f, input logic [7:0] r, input logic [15:0] id);
    return {r, f, id};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic db);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_db = db; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, input logic db, output logic [31:0] d);
    cfg_addr = a; cfg_db = db;
    #0.5;
    d = cfg_rdata;
  endtask

  function automatic logic [NS*SW-1:0] pack_bank(input logic sec);
    logic [NS*SW-1:0] v;
    for (int i = 0; i < NS; i++) v[i*SW +: SW] = sec ? m_sec[i] : m_pri[i];
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < NS; i++) begin m_pri[i] = '0; m_sec[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    rd(mk_addr(0, 0, MY_ID), 1'b0, d); chk("R9 reset primary", 64'(d), 64'd0);
    rd(mk_addr(1, 3, MY_ID), 1'b1, d); chk("R9 reset secondary", 64'(d), 64'd0);
    chk("R9 reset route_sel", 64'(route_sel), 64'd0);

    // R1 R3 R6 table walk
    for (int k = 0; k < 10; k++) begin
      logic [7:0] f; logic [7:0] r; logic b; logic [31:0] v;
      {f, r, b, v} = VEC[k];
      wr(mk_addr(f, r, MY_ID), v, b);
      if (b) m_sec[f*NR + r] = v[SW-1:0]; else m_pri[f*NR + r] = v[SW-1:0];
      rd(mk_addr(f, r, MY_ID), b, d);
      chk("R6 readback after write", 64'(d), 64'(v));
    end

    // R7 readback bank follows cfg_db
    for (int i = 0; i < NS; i++) begin
      rd(mk_addr(8'(i / NR), 8'(i % NR), MY_ID), 1'b0, d);
      chk("R7 primary readback", 64'(d), 64'(m_pri[i]));
      rd(mk_addr(8'(i / NR), 8'(i % NR), MY_ID), 1'b1, d);
      chk("R7 secondary readback", 64'(d), 64'(m_sec[i]));
    end

    // R4 R5 bank switch with no clock edge
    @(negedge clk);
    use_db = 1'b0; #0.5;
    chk("R4 primary drives route_sel", 64'(route_sel), 64'(pack_bank(1'b0)));
    #0.5 use_db = 1'b1; #0.5;
    chk("R5 secondary drives route_sel", 64'(route_sel), 64'(pack_bank(1'b1)));
    #0.5 use_db = 1'b0; #0.5;
    chk("R4 back to primary", 64'(route_sel), 64'(pack_bank(1'b0)));

    // R3 primary write keeps secondary intact, live route follows primary
    wr(mk_addr(0, 2, MY_ID), 32'h0000_0004, 1'b0); m_pri[2] = 4'h4;
    rd(mk_addr(0, 2, MY_ID), 1'b1, d); chk("R3 secondary untouched", 64'(d), 64'(m_sec[2]));
    chk("R4 live route updated", 64'(route_sel), 64'(pack_bank(1'b0)));

    // R2 foreign tile write ignored and reads zero
    wr(mk_addr(0, 0, MY_ID ^ 16'h0100), 32'h0000_0008, 1'b0);
    rd(mk_addr(0, 0, MY_ID ^ 16'h0100), 1'b0, d); chk("R2 foreign reads zero", 64'(d), 64'd0);
    rd(mk_addr(0, 0, MY_ID), 1'b0, d); chk("R2 foreign write ignored", 64'(d), 64'(m_pri[0]));
    chk("R2 route_sel unchanged", 64'(route_sel), 64'(pack_bank(1'b0)));

    // R8 unused feature and register codes
    wr(mk_addr(8'd2, 8'd0, MY_ID), 32'h0000_000B, 1'b0);
    rd(mk_addr(8'd2, 8'd0, MY_ID), 1'b0, d); chk("R8 bad feature reads zero", 64'(d), 64'd0);
    wr(mk_addr(8'd0, 8'd4, MY_ID), 32'h0000_000D, 1'b1);
    rd(mk_addr(8'd0, 8'd4, MY_ID), 1'b1, d); chk("R8 bad register reads zero", 64'(d), 64'd0);
    chk("R8 primary unchanged", 64'(route_sel), 64'(pack_bank(1'b0)));
    use_db = 1'b1; #0.5;
    chk("R8 secondary unchanged", 64'(route_sel), 64'(pack_bank(1'b1)));

    // R6 upper data bits dropped
    wr(mk_addr(1, 1, MY_ID), 32'hFFFF_FFF2, 1'b1); m_sec[NR + 1] = 4'h2;
    rd(mk_addr(1, 1, MY_ID), 1'b1, d); chk("R6 upper bits zero", 64'(d), 64'h2);
    #0.5;
    chk("R5 route_sel follows new secondary", 64'(route_sel), 64'(pack_bank(1'b1)));

    // R9 reset with use_db high
    @(negedge clk);
    rst_n = 1'b0; #0.5;
    chk("R9 primary during reset", 64'(route_sel), 64'(pack_bank(1'b0)));
    @(negedge clk); @(negedge clk);
    chk("R9 cleared during reset", 64'(route_sel), 64'd0);
    rst_n = 1'b1; #0.5;
    for (int i = 0; i < NS; i++) begin m_pri[i] = '0; m_sec[i] = '0; end
    chk("R9 secondary cleared", 64'(route_sel), 64'd0);
    rd(mk_addr(0, 0, MY_ID), 1'b0, d); chk("R9 primary cleared", 64'(d), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule